// File: doc/BRIEF.md
# Sector Flash Command Sequencer

This block is the control core on the device side of a sector-organised flash array. The array is reached over one byte-wide bus, and that bus carries commands, address bytes and data. A select input sorts the byte on the bus into one of two classes: a command or data byte, or an address byte. A write strobe latches commands and addresses. A separate serial-clock strobe moves data bytes into or out of the array one byte at a time. The block decodes the operation and gathers the two-byte sector address. It keeps a column pointer for streamed reads and program loads, and the host may move that pointer with two-byte column jumps in the middle of a transfer.

Erase and program operations start on a confirm byte. Each one then runs for a modelled busy period whose length arrives as a cycle count, and the ready output is held low for that time. The byte the block drives back is one of three things: array data during a read, a fixed identifier during an identifier read, or a status byte at all other times. The array itself is not part of the block. The block presents a sector, a column, a source select and write pulses, and it reports completion with a done pulse together with the operation code.

All strobe inputs are single-cycle pulses that are already synchronous to `clk`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `rdy` is 1, `bus_out_vld` is 1, `bus_out` is the status byte 80h, and `wr_en` and `op_done` are both 0.
- R2: A byte is decoded as a command when `cd_sel` is 0 and `wr_stb` pulses. It is taken as an address byte when `cd_sel` is 1. The first sector byte supplies `arr_sector[7:0]` and bits 6:0 of the second supply `arr_sector[14:8]`.
- R3: Command 00h, followed by two sector bytes, enters a streamed read from column 0. `bus_out` shows the array byte at (`arr_sector`, `arr_col`) with `bus_out_vld`=1, and each `sclk_stb` advances the column by one.
- R4: Command F0h reads the spare area: after the sector bytes, the column starts at 2048.
- R5: During a transfer for 00h, 10h or 11h, a pair of address bytes moves the column pointer: the low 8 bits first, then bits 11:8 from bits 3:0 of the second byte. Pairs can be repeated any number of times.
- R6: Once the column reaches 2112 it stays there. Read output is then flagged invalid (`bus_out_vld`=0) and serial clocks produce no writes.
- R7: During a transfer for the program commands 10h, 1Fh, 0Fh and 11h, each `sclk_stb` produces a one-cycle `wr_en` in the next cycle, carrying the current column and the bus byte, and then advances the column. 0Fh starts at column 2048. An address byte during a 1Fh or 0Fh transfer returns the block to idle.
- R8: Three sequences start a busy period: 20h, sector, sector, B0h; a program command, sector, sector, data, then 40h; and 12h, sector, sector, 40h. `rdy` is 0 for max(1, `busy_len`) cycles. `op_done` pulses for one cycle as `rdy` returns, with `op_code` equal to the starting command.
- R9: While busy, every write strobe and serial clock is ignored, reset command FFh included.
- R10: If `busy_len` exceeds BUSY_MAX, the busy period lasts BUSY_MAX cycles and bit 0 of the status byte is set afterwards. Command 50h or FFh clears it. Status bit 7 is `rdy`, and the other bits read 0.
- R11: After command 90h, `bus_out` is 07h while `cd_sel` is 0 and 9Dh while `cd_sel` is 1.
- R12: An unrecognised command byte, or an address byte outside an address phase, returns the block to idle. A later confirm byte then starts nothing.
- R13: Command 01h reads back the program load buffer (`arr_buf_sel`=1) from column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_in | input | 8 | Command, address or data byte |
| cd_sel | input | 1 | 0: command/data byte, 1: address byte |
| wr_stb | input | 1 | Write strobe pulse (command/address latch) |
| sclk_stb | input | 1 | Serial clock pulse (data in/out) |
| busy_len | input | BUSY_W | Modelled busy duration in cycles |
| arr_rdata | input | 8 | Array or buffer byte at the presented location |
| bus_out | output | 8 | Read data, identifier or status byte |
| bus_out_vld | output | 1 | `bus_out` is meaningful |
| rdy | output | 1 | 1 = ready, 0 = busy |
| arr_sector | output | SEC_W | Latched sector |
| arr_col | output | COL_W | Column pointer |
| arr_buf_sel | output | 1 | Read source is the load buffer |
| wr_en | output | 1 | Program data byte write pulse |
| wr_col | output | COL_W | Column of the write |
| wr_data | output | 8 | Byte to write |
| op_done | output | 1 | Busy operation finished |
| op_code | output | 8 | Command of the current operation |

## Verification
On every cycle, the embedded assertions check a set of structural rules. The state machine and the busy timer must agree on being busy, and the busy count must stay below its capped target. The sector and operation stay frozen while busy, the column holds once it reaches the sector end, and a write pulse only comes from a program transfer inside the sector. Other behaviour depends on whole command sequences, and only the bench's scenarios show it. This covers decoding of each command and the column jumps in mid-transfer, the exact length of the busy window and the timeout flag, the identifier selection, the rejection of misplaced bytes, and the data read back after program and erase. For these, the bench runs a behavioural model of the array and the sequencer and compares against it on every clock.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SA1,
        S_SA2,
        S_CONF,
        S_XFER,
        S_ID,
        S_BUSY
    } seq_st_e;

    localparam logic [7:0] C_RD_ALL   = 8'h00;
    localparam logic [7:0] C_RD_SPR   = 8'hF0;
    localparam logic [7:0] C_ID       = 8'h90;
    localparam logic [7:0] C_RCV_RD   = 8'h01;
    localparam logic [7:0] C_ERASE    = 8'h20;
    localparam logic [7:0] C_PG_ADD   = 8'h10;
    localparam logic [7:0] C_PG_FRESH = 8'h1F;
    localparam logic [7:0] C_PG_SPR   = 8'h0F;
    localparam logic [7:0] C_PG_OVR   = 8'h11;
    localparam logic [7:0] C_RCV_WR   = 8'h12;
    localparam logic [7:0] C_RESET    = 8'hFF;
    localparam logic [7:0] C_CLR      = 8'h50;
    localparam logic [7:0] C_GO_ERASE = 8'hB0;
    localparam logic [7:0] C_GO_PROG  = 8'h40;

    localparam logic [7:0] ID_LO = 8'h07;
    localparam logic [7:0] ID_HI = 8'h9D;

    function automatic logic is_prog(input logic [7:0] c);
        return (c == C_PG_ADD) || (c == C_PG_FRESH) || (c == C_PG_SPR) || (c == C_PG_OVR);
    endfunction

    function automatic logic is_read(input logic [7:0] c);
        return (c == C_RD_ALL) || (c == C_RD_SPR) || (c == C_RCV_RD);
    endfunction

    function automatic logic is_spare(input logic [7:0] c);
        return (c == C_RD_SPR) || (c == C_PG_SPR);
    endfunction

    function automatic logic col_jump_ok(input logic [7:0] c);
        return (c == C_RD_ALL) || (c == C_PG_ADD) || (c == C_PG_OVR);
    endfunction

    function automatic logic needs_conf(input logic [7:0] c);
        return (c == C_ERASE) || (c == C_RCV_WR);
    endfunction

    function automatic logic takes_sector(input logic [7:0] c);
        return (c == C_RD_ALL) || (c == C_RD_SPR) || (c == C_ERASE) ||
               (c == C_RCV_WR) || is_prog(c);
    endfunction

endpackage

// File: rtl/flc_busy_tmr.sv
module flc_busy_tmr #(
    parameter int BUSY_W   = 12,
    parameter int BUSY_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUSY_W-1:0] len,
    output logic              busy,
    output logic              done,
    output logic              timed_out
);
    localparam logic [BUSY_W-1:0] MAX_V = BUSY_W'(BUSY_MAX);
    localparam logic [BUSY_W-1:0] ONE   = BUSY_W'(1);

    typedef struct packed {
        logic              busy;
        logic              to;
        logic [BUSY_W-1:0] cnt;
        logic [BUSY_W-1:0] tgt;
    } tmr_t;

    tmr_t r_q, r_d;
    logic fin;

    always_comb begin
        r_d = r_q;
        fin = r_q.busy && ((r_q.cnt + ONE) == r_q.tgt);
        if (start && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.to   = (len > MAX_V);
            if (len == '0)
                r_d.tgt = ONE;
            else if (len > MAX_V)
                r_d.tgt = MAX_V;
            else
                r_d.tgt = len;
        end else if (fin) begin
            r_d.busy = 1'b0;
        end else if (r_q.busy) begin
            r_d.cnt = r_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = r_q.busy;
    assign done      = fin;
    assign timed_out = r_q.to;

    a_r8_cnt_below_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.cnt < r_q.tgt));

    a_r10_target_capped: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.tgt <= MAX_V && r_q.tgt != '0));

endmodule

// File: rtl/flc_col_ptr.sv
module flc_col_ptr #(
    parameter int COL_W        = 12,
    parameter int SECTOR_BYTES = 2112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] load_val,
    input  logic             adv,
    output logic [COL_W-1:0] col,
    output logic             in_range
);
    localparam logic [COL_W-1:0] END_V = COL_W'(SECTOR_BYTES);
    localparam logic [COL_W-1:0] ONE   = COL_W'(1);

    typedef struct packed {
        logic [COL_W-1:0] col;
    } ptr_t;

    ptr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load)
            r_d.col = load_val;
        else if (adv && (r_q.col < END_V))
            r_d.col = r_q.col + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign col      = r_q.col;
    assign in_range = (r_q.col < END_V);

    a_r6_hold_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_range && !load) |=> $stable(col));

endmodule

// File: rtl/flc_seq.sv
module flc_seq
    import flc_pkg::*;
#(
    parameter int SEC_W        = 15,
    parameter int COL_W        = 12,
    parameter int SECTOR_BYTES = 2112,
    parameter int SPARE_BASE   = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_in,
    input  logic             cd_sel,
    input  logic             wr_stb,
    input  logic             sclk_stb,
    input  logic [COL_W-1:0] col,
    input  logic             col_ok,
    input  logic             tmr_done,
    input  logic             tmr_to,
    output seq_st_e          st,
    output logic [7:0]       kind,
    output logic [SEC_W-1:0] sector,
    output logic             fail,
    output logic             col_load,
    output logic [COL_W-1:0] col_val,
    output logic             col_adv,
    output logic             tmr_start,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data,
    output logic             done
);
    localparam int SEC_HI_W = SEC_W - 8;
    localparam int COL_HI_W = COL_W - 8;
    localparam logic [COL_W-1:0] SPARE_V = COL_W'(SPARE_BASE);

    typedef struct packed {
        seq_st_e          st;
        logic [7:0]       kind;
        logic [SEC_W-1:0] sec;
        logic [7:0]       ca_lo;
        logic             ca_half;
        logic             fail;
        logic             wen;
        logic [COL_W-1:0] wcol;
        logic [7:0]       wdata;
        logic             done;
    } seq_t;

    seq_t r_q, r_d;
    logic confirm_hit;

    always_comb begin
        r_d       = r_q;
        r_d.wen   = 1'b0;
        r_d.done  = 1'b0;
        col_load  = 1'b0;
        col_val   = '0;
        col_adv   = 1'b0;
        tmr_start = 1'b0;

        confirm_hit =
            ((r_q.st == S_CONF) &&
             (((r_q.kind == C_ERASE) && (bus_in == C_GO_ERASE)) ||
              ((r_q.kind == C_RCV_WR) && (bus_in == C_GO_PROG)))) ||
            ((r_q.st == S_XFER) && is_prog(r_q.kind) && (bus_in == C_GO_PROG));

        if (r_q.st == S_BUSY) begin
            if (tmr_done) begin
                r_d.st   = S_IDLE;
                r_d.done = 1'b1;
                r_d.fail = tmr_to;
            end
        end else if (wr_stb && !cd_sel) begin
            r_d.ca_half = 1'b0;
            if (confirm_hit) begin
                r_d.st    = S_BUSY;
                tmr_start = 1'b1;
            end else if (takes_sector(bus_in)) begin
                r_d.st   = S_SA1;
                r_d.kind = bus_in;
            end else if (bus_in == C_ID) begin
                r_d.st   = S_ID;
                r_d.kind = bus_in;
            end else if (bus_in == C_RCV_RD) begin
                r_d.st   = S_XFER;
                r_d.kind = bus_in;
                col_load = 1'b1;
                col_val  = '0;
            end else begin
                r_d.st = S_IDLE;
                if ((bus_in == C_RESET) || (bus_in == C_CLR))
                    r_d.fail = 1'b0;
            end
        end else if (wr_stb) begin
            case (r_q.st)
                S_SA1: begin
                    r_d.sec[7:0] = bus_in;
                    r_d.st       = S_SA2;
                end
                S_SA2: begin
                    r_d.sec[SEC_W-1:8] = bus_in[SEC_HI_W-1:0];
                    r_d.st   = needs_conf(r_q.kind) ? S_CONF : S_XFER;
                    col_load = 1'b1;
                    col_val  = is_spare(r_q.kind) ? SPARE_V : '0;
                end
                S_XFER: begin
                    if (col_jump_ok(r_q.kind)) begin
                        if (!r_q.ca_half) begin
                            r_d.ca_lo   = bus_in;
                            r_d.ca_half = 1'b1;
                        end else begin
                            col_load    = 1'b1;
                            col_val     = {bus_in[COL_HI_W-1:0], r_q.ca_lo};
                            r_d.ca_half = 1'b0;
                        end
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end
                default: r_d.st = S_IDLE;
            endcase
        end else if (sclk_stb && (r_q.st == S_XFER) && col_ok) begin
            col_adv = 1'b1;
            if (is_prog(r_q.kind)) begin
                r_d.wen   = 1'b1;
                r_d.wcol  = col;
                r_d.wdata = bus_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign st      = r_q.st;
    assign kind    = r_q.kind;
    assign sector  = r_q.sec;
    assign fail    = r_q.fail;
    assign wr_en   = r_q.wen;
    assign wr_col  = r_q.wcol;
    assign wr_data = r_q.wdata;
    assign done    = r_q.done;

    a_r9_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_BUSY && !tmr_done) |=>
            (r_q.st == S_BUSY && $stable(r_q.kind) && $stable(r_q.sec)));

    a_r7_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wen |-> (is_prog(r_q.kind) && r_q.wcol < COL_W'(SECTOR_BYTES)));

    a_r8_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_d.done |-> (r_q.st == S_BUSY));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flc_pkg::*;
#(
    parameter int SEC_W        = 15,
    parameter int COL_W        = 12,
    parameter int SECTOR_BYTES = 2112,
    parameter int SPARE_BASE   = 2048,
    parameter int BUSY_W       = 12,
    parameter int BUSY_MAX     = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_in,
    input  logic              cd_sel,
    input  logic              wr_stb,
    input  logic              sclk_stb,
    input  logic [BUSY_W-1:0] busy_len,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        bus_out,
    output logic              bus_out_vld,
    output logic              rdy,
    output logic [SEC_W-1:0]  arr_sector,
    output logic [COL_W-1:0]  arr_col,
    output logic              arr_buf_sel,
    output logic              wr_en,
    output logic [COL_W-1:0]  wr_col,
    output logic [7:0]        wr_data,
    output logic              op_done,
    output logic [7:0]        op_code
);
    seq_st_e          st;
    logic [7:0]       kind;
    logic             fail;
    logic             col_load, col_adv, col_ok;
    logic [COL_W-1:0] col_val, col;
    logic             tmr_start, tmr_busy, tmr_done, tmr_to;

    flc_seq #(
        .SEC_W(SEC_W), .COL_W(COL_W),
        .SECTOR_BYTES(SECTOR_BYTES), .SPARE_BASE(SPARE_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .cd_sel(cd_sel),
        .wr_stb(wr_stb), .sclk_stb(sclk_stb), .col(col), .col_ok(col_ok),
        .tmr_done(tmr_done), .tmr_to(tmr_to), .st(st), .kind(kind),
        .sector(arr_sector), .fail(fail), .col_load(col_load),
        .col_val(col_val), .col_adv(col_adv), .tmr_start(tmr_start),
        .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data), .done(op_done)
    );

    flc_col_ptr #(.COL_W(COL_W), .SECTOR_BYTES(SECTOR_BYTES)) u_col (
        .clk(clk), .rst_n(rst_n), .load(col_load), .load_val(col_val),
        .adv(col_adv), .col(col), .in_range(col_ok)
    );

    flc_busy_tmr #(.BUSY_W(BUSY_W), .BUSY_MAX(BUSY_MAX)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(busy_len),
        .busy(tmr_busy), .done(tmr_done), .timed_out(tmr_to)
    );

    assign rdy         = (st != S_BUSY);
    assign arr_col     = col;
    assign arr_buf_sel = (kind == C_RCV_RD);
    assign op_code     = kind;

    always_comb begin
        if (st == S_ID) begin
            bus_out     = cd_sel ? ID_HI : ID_LO;
            bus_out_vld = 1'b1;
        end else if ((st == S_XFER) && is_read(kind)) begin
            bus_out     = arr_rdata;
            bus_out_vld = col_ok;
        end else begin
            bus_out     = {rdy, 6'b000000, fail};
            bus_out_vld = 1'b1;
        end
    end

    a_r8_busy_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY) == tmr_busy);

    a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> rdy);

    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> !wr_en);

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

    localparam int SB   = 2112;
    localparam int MAXB = 200;
    localparam int M_IDLE = 0, M_SA1 = 1, M_SA2 = 2, M_CONF = 3, M_XFER = 4, M_ID = 5, M_BUSY = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]  t_bus = 8'h00;
    logic        t_cd = 1'b0, t_wr = 1'b0, t_sc = 1'b0;
    logic [11:0] t_len = 12'd1;
    logic [7:0]  arr_rdata;
    logic [7:0]  bus_out, op_code, wr_data;
    logic        bus_out_vld, rdy, arr_buf_sel, wr_en, op_done;
    logic [14:0] arr_sector;
    logic [11:0] arr_col, wr_col;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_in(t_bus), .cd_sel(t_cd), .wr_stb(t_wr),
        .sclk_stb(t_sc), .busy_len(t_len), .arr_rdata(arr_rdata), .bus_out(bus_out),
        .bus_out_vld(bus_out_vld), .rdy(rdy), .arr_sector(arr_sector), .arr_col(arr_col),
        .arr_buf_sel(arr_buf_sel), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
        .op_done(op_done), .op_code(op_code)
    );

    // behavioural array (two sectors, picked by sector bit 0) and load buffer
    logic [7:0] mem  [0:2*SB-1];
    logic [7:0] pbuf [0:SB-1];
    bit         pv   [0:SB-1];

    always_comb begin
        if (int'(arr_col) < SB)
            arr_rdata = arr_buf_sel ? pbuf[arr_col] : mem[int'(arr_sector[0]) * SB + int'(arr_col)];
        else
            arr_rdata = 8'h00;
    end

    int n_chk = 0, n_bad = 0, cycles = 0;
    int m_st = M_IDLE, m_kind = 0, m_sec = 0, m_lo = 0, m_col = 0, m_calo = 0;
    int m_cnt = 0, m_tgt = 0, m_wcol = 0, m_wdata = 0;
    bit m_half = 0, m_fail = 0, m_to = 0, m_wen = 0, m_done = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit k_prog(input int k);
        return k == 'h10 || k == 'h1F || k == 'h0F || k == 'h11;
    endfunction
    function automatic bit k_read(input int k);
        return k == 'h00 || k == 'hF0 || k == 'h01;
    endfunction

    task automatic commit();
        int base = (m_sec % 2) * SB;
        for (int c = 0; c < SB; c++) begin
            if (m_kind == 'h20) mem[base + c] = 8'hFF;
            else if (pv[c]) begin
                if (m_kind == 'h11 || m_kind == 'h12) mem[base + c] = pbuf[c];
                else mem[base + c] = mem[base + c] & pbuf[c];
            end
        end
    endtask

    task automatic model_step();
        int b = int'(t_bus);
        m_wen = 0; m_done = 0;
        if (m_st == M_BUSY) begin
            m_cnt++;
            if (m_cnt == m_tgt) begin
                m_st = M_IDLE; m_done = 1; m_fail = m_to;
                if (!m_to) commit();
            end
        end else if (t_wr && !t_cd) begin
            m_half = 0;
            if ((m_st == M_CONF && ((m_kind == 'h20 && b == 'hB0) || (m_kind == 'h12 && b == 'h40))) ||
                (m_st == M_XFER && k_prog(m_kind) && b == 'h40)) begin
                m_st = M_BUSY; m_cnt = 0;
                m_to = int'(t_len) > MAXB;
                m_tgt = (t_len == 0) ? 1 : (m_to ? MAXB : int'(t_len));
            end else begin
                case (b)
                    'h00, 'hF0, 'h20, 'h10, 'h1F, 'h0F, 'h11, 'h12: begin
                        m_st = M_SA1; m_kind = b;
                        if (k_prog(b)) for (int c = 0; c < SB; c++) pv[c] = 0;
                    end
                    'h90: begin m_st = M_ID; m_kind = b; end
                    'h01: begin m_st = M_XFER; m_kind = b; m_col = 0; end
                    'hFF, 'h50: begin m_st = M_IDLE; m_fail = 0; end
                    default: m_st = M_IDLE;
                endcase
            end
        end else if (t_wr) begin
            case (m_st)
                M_SA1: begin m_lo = b; m_st = M_SA2; end
                M_SA2: begin
                    m_sec = ((b & 'h7F) << 8) | m_lo;
                    m_st  = (m_kind == 'h20 || m_kind == 'h12) ? M_CONF : M_XFER;
                    m_col = (m_kind == 'hF0 || m_kind == 'h0F) ? 2048 : 0;
                end
                M_XFER: begin
                    if (m_kind == 'h00 || m_kind == 'h10 || m_kind == 'h11) begin
                        if (!m_half) begin m_calo = b; m_half = 1; end
                        else begin m_col = ((b & 'hF) << 8) | m_calo; m_half = 0; end
                    end else m_st = M_IDLE;
                end
                default: m_st = M_IDLE;
            endcase
        end else if (t_sc && m_st == M_XFER && m_col < SB) begin
            if (k_prog(m_kind)) begin
                m_wen = 1; m_wcol = m_col; m_wdata = b;
                pbuf[m_col] = t_bus; pv[m_col] = 1;
            end
            m_col++;
        end
    endtask

    task automatic compare();
        int  e_rdy = (m_st != M_BUSY);
        bit  e_vld;
        int  e_dout;
        string tg;
        if (m_st == M_ID) begin
            e_vld = 1; e_dout = t_cd ? 'h9D : 'h07; tg = "R11";
        end else if (m_st == M_XFER && k_read(m_kind)) begin
            e_vld = m_col < SB; tg = "R3";
            e_dout = !e_vld ? 0 : (m_kind == 'h01) ? int'(pbuf[m_col]) : int'(mem[(m_sec % 2) * SB + m_col]);
        end else begin
            e_vld = 1; e_dout = (e_rdy << 7) | int'(m_fail); tg = "R10";
        end
        chk("R8", "rdy", int'(rdy), e_rdy);
        chk(tg, "bus_out_vld", int'(bus_out_vld), int'(e_vld));
        if (e_vld) chk(tg, "bus_out", int'(bus_out), e_dout);
        chk("R7", "wr_en", int'(wr_en), int'(m_wen));
        if (m_wen) begin
            chk("R7", "wr_col", int'(wr_col), m_wcol);
            chk("R7", "wr_data", int'(wr_data), m_wdata);
        end
        chk("R8", "op_done", int'(op_done), int'(m_done));
        if (m_done) chk("R8", "op_code", int'(op_code), m_kind);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        cycles++;
    endtask

    task automatic wcmd(input logic [7:0] b);
        t_cd = 0; t_bus = b; t_wr = 1; cyc(); t_wr = 0;
    endtask
    task automatic wadr(input logic [7:0] b);
        t_cd = 1; t_bus = b; t_wr = 1; cyc(); t_wr = 0; t_cd = 0;
    endtask
    task automatic sclk(input logic [7:0] b);
        t_cd = 0; t_bus = b; t_sc = 1; cyc(); t_sc = 0;
    endtask
    task automatic idle(input int n, input logic cdv);
        t_cd = cdv;
        for (int i = 0; i < n; i++) cyc();
        t_cd = 0;
    endtask
    task automatic run_busy(input int exp_len, input string tag);
        int n = 0;
        while (!rdy && n < 1000) begin n++; cyc(); end
        chk(tag, "busy cycles", n, exp_len);
        idle(1, 0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2 * SB; i++) mem[i] = 8'((i * 7 + 3) & 255);
        for (int i = 0; i < SB; i++) begin pbuf[i] = 8'hFF; pv[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "rdy", int'(rdy), 1);
        chk("R1", "bus_out_vld", int'(bus_out_vld), 1);
        chk("R1", "bus_out", int'(bus_out), 'h80);
        chk("R1", "wr_en", int'(wr_en), 0);
        chk("R1", "op_done", int'(op_done), 0);

        // R11 identifier selected by cd_sel
        wcmd(8'h90);
        chk("R11", "id low", int'(bus_out), 'h07);
        idle(1, 1);
        t_cd = 1; #0.1;
        chk("R11", "id high", int'(bus_out), 'h9D);
        idle(1, 0);

        // R2/R3 full read of sector 1201h
        wcmd(8'h00); wadr(8'h01); wadr(8'h12);
        chk("R2", "arr_sector", int'(arr_sector), 'h1201);
        chk("R3", "start col", int'(arr_col), 0);
        for (int i = 0; i < 5; i++) sclk(8'h00);

        // R5 column jump to 834h, R6 saturation past the sector end
        wadr(8'h34); wadr(8'h08);
        chk("R5", "jump col", int'(arr_col), 'h834);
        for (int i = 0; i < 15; i++) sclk(8'h00);
        chk("R6", "col held", int'(arr_col), SB);
        chk("R6", "vld off", int'(bus_out_vld), 0);
        wadr(8'h05); wadr(8'h00);
        chk("R5", "second jump", int'(arr_col), 5);
        sclk(8'h00); sclk(8'h00);

        // R4 spare read
        wcmd(8'hF0); wadr(8'h00); wadr(8'h00);
        chk("R4", "spare col", int'(arr_col), 2048);
        for (int i = 0; i < 3; i++) sclk(8'h00);

        // R7/R8 program with column jumps, then check data by read
        wcmd(8'h10); wadr(8'h00); wadr(8'h00);
        sclk(8'hA5); sclk(8'h3C);
        wadr(8'h40); wadr(8'h08);
        sclk(8'h11);
        chk("R6", "no write past end", int'(wr_en), 0);
        wadr(8'h10); wadr(8'h00);
        sclk(8'h0F);
        t_len = 12'd5;
        wcmd(8'h40);
        run_busy(5, "R8");
        wcmd(8'h00); wadr(8'h00); wadr(8'h00);
        for (int i = 0; i < 3; i++) sclk(8'h00);

        // R9 everything ignored while busy (erase of sector 0)
        t_len = 12'd12;
        wcmd(8'h20); wadr(8'h00); wadr(8'h00); wcmd(8'hB0);
        wcmd(8'hFF);
        chk("R9", "FF ignored", int'(rdy), 0);
        wcmd(8'h90); sclk(8'h00); wadr(8'h33);
        chk("R9", "still busy", int'(rdy), 0);
        run_busy(8, "R9");
        wcmd(8'h00); wadr(8'h00); wadr(8'h00);
        sclk(8'h00); sclk(8'h00);
        chk("R8", "erased byte", int'(bus_out), 'hFF);

        // zero length busy lasts one cycle
        t_len = 12'd0;
        wcmd(8'h20); wadr(8'h00); wadr(8'h00); wcmd(8'hB0);
        run_busy(1, "R8");

        // R7 spare program, then address byte during 1Fh returns to idle
        wcmd(8'h0F); wadr(8'h01); wadr(8'h00);
        chk("R7", "spare prog col", int'(arr_col), 2048);
        sclk(8'h5A); sclk(8'hC3);
        t_len = 12'd3;
        wcmd(8'h40);
        run_busy(3, "R7");
        wcmd(8'h1F); wadr(8'h01); wadr(8'h00);
        wadr(8'h02);
        sclk(8'h77);
        chk("R7", "no write after abort", int'(wr_en), 0);
        wcmd(8'h40);
        chk("R7", "no busy after abort", int'(rdy), 1);

        // R12 unknown command and misplaced address bytes
        wcmd(8'h20); wadr(8'h00); wcmd(8'h77); wadr(8'h00); wcmd(8'hB0);
        chk("R12", "no busy", int'(rdy), 1);
        wadr(8'h12); wcmd(8'h40);
        chk("R12", "idle addr ignored", int'(rdy), 1);

        // R10 timeout, cleared by 50h
        t_len = 12'd300;
        wcmd(8'h11); wadr(8'h01); wadr(8'h00);
        sclk(8'h99); sclk(8'h88);
        wcmd(8'h40);
        run_busy(MAXB, "R10");
        chk("R10", "fail flag", int'(bus_out), 'h81);
        wcmd(8'h50);
        chk("R10", "cleared by 50h", int'(bus_out), 'h80);

        // R13 recovery read of the load buffer
        wcmd(8'h01);
        chk("R13", "buf select", int'(arr_buf_sel), 1);
        chk("R13", "buf byte0", int'(bus_out), 'h99);
        sclk(8'h00); sclk(8'h00);

        // R8 recovery write to sector 1, read back
        t_len = 12'd4;
        wcmd(8'h12); wadr(8'h01); wadr(8'h00); wcmd(8'h40);
        run_busy(4, "R8");
        wcmd(8'h00); wadr(8'h01); wadr(8'h00);
        chk("R8", "rewritten byte", int'(bus_out), 'h99);
        sclk(8'h00);

        // R10 second timeout cleared by FFh
        t_len = 12'd250;
        wcmd(8'h20); wadr(8'h00); wadr(8'h00); wcmd(8'hB0);
        run_busy(MAXB, "R10");
        chk("R10", "fail again", int'(bus_out), 'h81);
        wcmd(8'hFF);
        chk("R10", "cleared by FFh", int'(bus_out), 'h80);
        idle(2, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule